// File: doc/BRIEF.md
# In-Band Flow Calendar Extractor

This block sits on the receive side of a packet link that carries flow-control information inside its 64-bit control words. Every control word, whether it opens a burst or is an idle filler, carries one 16-bit slice ("page") of a wider flow-control calendar. A marker bit in the word flags the first page of a new round. The block watches the word stream, collects the pages of each round in a hidden register and then publishes the whole calendar at once. As a result, downstream logic never sees a mix of two rounds.

The calendar width is a parameter and must be a multiple of 16. The first page of a round fills the most significant 16 bits, and each later page fills the next lower slice. This matches the order in which a transmitter packs its calendar vector into pages, so a looped-back link gives back the vector that was sent. A static enable parameter can remove the feature. When it is off, the output is held at all ones, which means nothing is flow controlled.

A sticky flag records that a new round started before the previous one was complete. Only reset clears it.

Top module: `calendar_recover`

## Requirements
- R1: A word counts only when `word_vld` is 1 and bits 63 and 62 of `word` are both 1. Any other word, including a valid-low cycle that carries a control pattern, leaves `cal_out` and `cal_misalign` unchanged.
- R2: A control word supplies its page from bits 55:40. Bit 56 is the round-start marker. Bit 61 (1 = idle filler, 0 = burst opener) has no effect, so both kinds contribute pages in the same way.
- R3: A control word with bit 56 set begins a new round, and its page becomes the most significant slice `cal_out[CAL_W-1 -: 16]`.
- R4: With N = CAL_W/16, page k of a round (k = 0 for the marked word) lands in `cal_out[CAL_W-1-16k : CAL_W-16-16k]`.
- R5: `cal_out` keeps its previous value while a round is incomplete. It takes the full new value at the clock edge that accepts the N-th page, so the change is visible in the following cycle.
- R6: A marked word that arrives after 1 to N-1 pages of a round discards those pages and starts a new round. It also sets `cal_misalign`, which stays at 1 until reset.
- R7: Unmarked control words are ignored in two cases: after N pages of a round and before the next marked word, and before the first marked word after reset.
- R8: While reset is active and after its release, `cal_out` is all ones and `cal_misalign` is 0 until a complete round has been accepted.
- R9: With ENABLE = 0, `cal_out` is constantly all ones and `cal_misalign` is constantly 0, whatever the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| word_vld | input | 1 | `word` carries a received word this cycle |
| word | input | 64 | Received word after framing and descrambling |
| cal_out | output | CAL_W | Published flow-control calendar |
| cal_misalign | output | 1 | Sticky flag: a round was restarted before it was complete |

## Verification
The bench builds three copies that share one input stream.

- A 64-bit copy has four pages per round. It exercises partial rounds, restarts at every page position, ignored surplus pages and the once-per-round update.
- A 16-bit copy has one page per round. In this copy every marked word completes a round immediately, so the boundary of the page counter is reached and a restart can never count as misaligned.
- A 48-bit copy with ENABLE = 0 checks that the output stays forced under the same traffic.

// File: rtl/calx_pkg.sv
// Package: shared constants and the decoded control-word record for the
// calendar extractor. Assumes 64-bit link words with the field layout below.
package calx_pkg;
    localparam int PAGE_W   = 16;
    localparam int PAGE_LO  = 40;
    localparam int MARK_BIT = 56;

    typedef struct packed {
        logic              ctrl;   // word is an accepted control word
        logic              mark;   // round-start marker
        logic [PAGE_W-1:0] page;   // calendar page carried by the word
    } ctl_info_t;
endpackage

// File: rtl/calx_decode.sv
// Module: calx_decode
// Classifies one incoming word and extracts its calendar page and marker.
// Assumes the word is already framed/descrambled; purely combinational.
module calx_decode
    import calx_pkg::*;
(
    input  logic        word_vld,
    input  logic [63:0] word,
    output ctl_info_t   info
);
    logic unused_fields;

    // Classify the word and slice out marker and page.
    always_comb begin
        info.ctrl = word_vld & word[63] & word[62];
        info.mark = word[MARK_BIT];
        info.page = word[PAGE_LO +: PAGE_W];
    end

    assign unused_fields = ^{word[61:57], word[39:0]};
endmodule

// File: rtl/calx_sequencer.sv
// Module: calx_sequencer
// Tracks position within a calendar round, chooses the shadow slot for each
// accepted page, signals completion and records premature restarts.
// Assumes PAGES >= 1; position 0 means "not aligned yet".
module calx_sequencer
    import calx_pkg::*;
#(
    parameter int PAGES = 4,
    localparam int IDX_W = (PAGES > 1) ? $clog2(PAGES) : 1,
    localparam int CNT_W = $clog2(PAGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_info_t        info,
    output logic             store,
    output logic [IDX_W-1:0] slot,
    output logic             commit,
    output logic             misalign
);
    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(PAGES);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(PAGES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             restart;
    logic             partial;

    assign partial = (cnt_q != '0) && (cnt_q < FULL_C);

    // Decide whether this word's page is stored, where, and if it closes a round.
    always_comb begin
        store   = 1'b0;
        slot    = '0;
        commit  = 1'b0;
        restart = 1'b0;
        if (info.ctrl) begin
            if (info.mark) begin
                store   = 1'b1;
                restart = 1'b1;
                commit  = (PAGES == 1);
            end else if (partial) begin
                store  = 1'b1;
                slot   = cnt_q[IDX_W-1:0];
                commit = (cnt_q == LAST_C);
            end
        end
    end

    // Advance the page position; a marker always restarts at one page held.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= CNT_W'(1);
        else if (store)   cnt_q <= cnt_q + CNT_W'(1);
    end

    // Latch the sticky flag when a marker cuts a round short.
    always_ff @(posedge clk) begin
        if (!rst_n)                  misalign <= 1'b0;
        else if (restart && partial) misalign <= 1'b1;
    end
endmodule

// File: rtl/calx_assemble.sv
// Module: calx_assemble
// Holds pages of the round in progress and publishes the merged calendar
// atomically on commit. Assumes store/slot/commit come from calx_sequencer.
module calx_assemble
    import calx_pkg::*;
#(
    parameter int PAGES = 4,
    localparam int IDX_W = (PAGES > 1) ? $clog2(PAGES) : 1,
    localparam int CAL_W = PAGES * PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store,
    input  logic [IDX_W-1:0]  slot,
    input  logic [PAGE_W-1:0] page,
    input  logic              commit,
    output logic [CAL_W-1:0]  cal_q
);
    logic [PAGE_W-1:0] shadow_q [PAGES];
    logic [CAL_W-1:0]  merged;

    // Merge the page arriving now with stored ones; slot 0 is most significant.
    for (genvar k = 0; k < PAGES; k++) begin : g_slice
        assign merged[CAL_W-1-PAGE_W*k -: PAGE_W] =
            (store && slot == IDX_W'(k)) ? page : shadow_q[k];
    end

    // Capture an accepted page into its shadow slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < PAGES; k++) shadow_q[k] <= '1;
        end else if (store) begin
            for (int k = 0; k < PAGES; k++)
                if (slot == IDX_W'(k)) shadow_q[k] <= page;
        end
    end

    // Publish the whole calendar once a round completes.
    always_ff @(posedge clk) begin
        if (!rst_n)      cal_q <= '1;
        else if (commit) cal_q <= merged;
    end
endmodule

// File: rtl/calendar_recover.sv
// Module: calendar_recover (top)
// Recovers the in-band flow-control calendar from received control words.
// Assumes CAL_W is a multiple of 16; ENABLE = 0 forces an all-ones output.
module calendar_recover
    import calx_pkg::*;
#(
    parameter int CAL_W  = 64,
    parameter bit ENABLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_vld,
    input  logic [63:0]      word,
    output logic [CAL_W-1:0] cal_out,
    output logic             cal_misalign
);
    localparam int PAGES = CAL_W / PAGE_W;
    localparam int IDX_W = (PAGES > 1) ? $clog2(PAGES) : 1;

    if (ENABLE) begin : g_on
        ctl_info_t        info;
        logic             store;
        logic             commit;
        logic [IDX_W-1:0] slot;

        calx_decode u_decode (
            .word_vld (word_vld),
            .word     (word),
            .info     (info)
        );

        calx_sequencer #(.PAGES(PAGES)) u_seq (
            .clk      (clk),
            .rst_n    (rst_n),
            .info     (info),
            .store    (store),
            .slot     (slot),
            .commit   (commit),
            .misalign (cal_misalign)
        );

        calx_assemble #(.PAGES(PAGES)) u_asm (
            .clk    (clk),
            .rst_n  (rst_n),
            .store  (store),
            .slot   (slot),
            .page   (info.page),
            .commit (commit),
            .cal_q  (cal_out)
        );
    end else begin : g_off
        logic unused_inputs;
        assign unused_inputs = ^{clk, rst_n, word_vld, word};
        assign cal_out       = '1;
        assign cal_misalign  = 1'b0;
    end
endmodule

// File: rtl/calx_checker.sv
// Module: calx_checker
// Port-level temporal checks for calendar_recover, attached by bind below.
module calx_checker #(
    parameter int CAL_W  = 64,
    parameter bit ENABLE = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             word_vld,
    input logic [63:0]      word,
    input logic [CAL_W-1:0] cal_out,
    input logic             cal_misalign
);
    logic unused_chk;
    assign unused_chk = ^{word[61:56], word[39:0]};

    p_ignore_other_words_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_vld && word[63] && word[62]) |=> ($stable(cal_out) && $stable(cal_misalign)));

    // R5: an update always ends with the page of the word that completed it
    p_update_ends_with_last_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cal_out) |-> (cal_out[15:0] == $past(word[55:40])));

    p_misalign_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cal_misalign |=> cal_misalign);

    p_reset_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cal_out == '1 && !cal_misalign));

    if (!ENABLE) begin : g_off_chk
        p_forced_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cal_out == '1) && !cal_misalign);
    end
endmodule

bind calendar_recover calx_checker #(.CAL_W(CAL_W), .ENABLE(ENABLE)) u_chk (.*);

// File: tb/tb_calendar_recover.sv
// Bench: three instances on one stream, compared each cycle to a queue model.
module tb_calendar_recover;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_vld = 1'b0;
    logic [63:0] word = '0;
    logic [63:0] cal64;
    logic [15:0] cal16;
    logic [47:0] cal48;
    logic        mis64, mis16, mis48;

    int    nchk = 0, nfail = 0;
    bit    done = 1'b0;
    string lbl = "R8";

    always #5 clk = ~clk;

    calendar_recover #(.CAL_W(64), .ENABLE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word(word),
        .cal_out(cal64), .cal_misalign(mis64));
    calendar_recover #(.CAL_W(16), .ENABLE(1'b1)) dut_one (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word(word),
        .cal_out(cal16), .cal_misalign(mis16));
    calendar_recover #(.CAL_W(48), .ENABLE(1'b0)) dut_off (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word(word),
        .cal_out(cal48), .cal_misalign(mis48));

    // Reference model: index 0 = 4 pages, index 1 = 1 page.
    int          m_n [2] = '{4, 1};
    bit [63:0]   m_cal [2];
    bit          m_mis [2];
    bit [15:0]   m_pg [2][$];

    function automatic logic [63:0] cw(bit rc, bit idl, logic [15:0] pg);
        return {2'b11, idl, 4'b0000, rc, pg, 40'h0};
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < 2; i++) begin
            m_cal[i] = '1;
            m_mis[i] = 1'b0;
            m_pg[i].delete();
        end
    endfunction

    function automatic void model_step(bit v, logic [63:0] w);
        for (int i = 0; i < 2; i++) begin
            bit took = 1'b0;
            if (v && w[63] && w[62]) begin
                if (w[56]) begin
                    if (m_pg[i].size() > 0 && m_pg[i].size() < m_n[i]) m_mis[i] = 1'b1;
                    m_pg[i].delete();
                    m_pg[i].push_back(w[55:40]);
                    took = 1'b1;
                end else if (m_pg[i].size() > 0 && m_pg[i].size() < m_n[i]) begin
                    m_pg[i].push_back(w[55:40]);
                    took = 1'b1;
                end
                if (took && m_pg[i].size() == m_n[i])
                    for (int k = 0; k < m_n[i]; k++)
                        m_cal[i][16*m_n[i]-1-16*k -: 16] = m_pg[i][k];
            end
        end
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk(cal64 == m_cal[0], lbl, "cal64", cal64, m_cal[0]);
        chk(mis64 == m_mis[0], lbl, "mis64", 64'(mis64), 64'(m_mis[0]));
        chk(cal16 == m_cal[1][15:0], lbl, "cal16", 64'(cal16), m_cal[1]);
        chk(mis16 == m_mis[1], lbl, "mis16", 64'(mis16), 64'(m_mis[1]));
        chk(cal48 == '1 && !mis48, "R9", "off", {15'b0, mis48, cal48}, {16'b0, 48'hFFFF_FFFF_FFFF});
    endtask

    task automatic step(bit v, logic [63:0] w);
        @(negedge clk);
        check_all();
        model_step(v, w);
        word_vld = v;
        word     = w;
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        chk(cal64 == '1 && !mis64, "R8", "reset cal64", cal64, '1);
        chk(cal16 == '1 && !mis16, "R8", "reset cal16", 64'(cal16), 64'hFFFF);
        rst_n = 1'b1;

        lbl = "R7"; // unmarked page before any marker
        step(1, cw(0, 0, 16'hDEAD));
        step(0, '0);
        chk(cal64 == '1, "R7", "pre-align page", cal64, '1);

        lbl = "R3";
        step(1, cw(1, 0, 16'h1111));
        lbl = "R2";
        step(1, cw(0, 1, 16'h2222));
        step(1, cw(0, 0, 16'h3333));
        step(0, '0);
        chk(cal64 == '1, "R5", "partial round hidden", cal64, '1);
        chk(cal16 == 16'h1111, "R3", "single-page msb", 64'(cal16), 64'h1111);
        lbl = "R4";
        step(1, cw(0, 1, 16'h4444));
        step(0, '0);
        chk(cal64 == 64'h1111_2222_3333_4444, "R4", "page order", cal64, 64'h1111_2222_3333_4444);

        lbl = "R7";
        step(1, cw(0, 0, 16'h5555));
        step(0, '0);
        chk(cal64 == 64'h1111_2222_3333_4444, "R7", "surplus page", cal64, 64'h1111_2222_3333_4444);

        lbl = "R1";
        step(1, 64'h3FFF_FFFF_FFFF_FFFF);
        step(1, {2'b10, 5'b0, 1'b1, 16'hBEEF, 40'h0});
        step(0, cw(1, 0, 16'hBEEF));
        step(0, '0);
        chk(cal64 == 64'h1111_2222_3333_4444 && cal16 == 16'h1111, "R1", "non-control words",
            cal64, 64'h1111_2222_3333_4444);

        lbl = "R6";
        step(1, cw(1, 0, 16'hAAAA));
        step(1, cw(0, 0, 16'hBBBB));
        step(1, cw(1, 1, 16'hC0C0));
        step(1, cw(0, 0, 16'hD1D1));
        step(1, cw(0, 1, 16'hE2E2));
        step(1, cw(0, 0, 16'hF3F3));
        step(0, '0);
        chk(cal64 == 64'hC0C0_D1D1_E2E2_F3F3, "R6", "restarted round", cal64, 64'hC0C0_D1D1_E2E2_F3F3);
        chk(mis64 && !mis16, "R6", "sticky flag", {mis16, mis64}, 64'h1);

        lbl = "R2";
        for (int k = 0; k < 4; k++) step(1, cw(k == 0, 1, 16'h0A0A + 16'(k)));
        step(0, '0);
        chk(cal64 == 64'h0A0A_0A0B_0A0C_0A0D, "R2", "all idle-type", cal64, 64'h0A0A_0A0B_0A0C_0A0D);

        lbl = "R8";
        @(negedge clk);
        rst_n = 1'b0;
        word_vld = 1'b0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        check_all();
        rst_n = 1'b1;

        lbl = "R5";
        for (int n = 0; n < 400; n++) begin
            int r = int'($urandom_range(0, 9));
            logic [63:0] w = {$urandom, $urandom};
            if (r < 7) w = cw(r == 0, w[61], w[55:40]);
            step(r != 9, w);
        end
        step(0, '0);
        step(0, '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule